// File: doc/BRIEF.md
# Slow-Domain Register Write Bridge

This block carries register writes from a fast bus clock into a slow retention-clock domain (nominally 32.768 kHz). A write to any synchronized address is accepted only while the bridge is idle. The bridge holds the address and data stable and passes a toggle request across a multi-flop synchronizer. The slow side presents the committed address and data with a one-cycle strobe, and its acknowledgement toggles back through a second synchronizer to close the transaction.

Software follows progress through four status flags: busy, ready-for-next, done and collision-error. Done clears itself whenever the status word is read. An interrupt-enable register lives in the bus domain and takes a write at once, with no trip through the slow domain. A second synchronized write issued while the bridge is busy is thrown away and raises the collision-error flag. That flag stays set until software writes a 1 to its bit position at the status address.

Top module: `lp_write_bridge`

## Requirements
- R1: After reset the status word reads 0x0000_0200 (only ready-for-next, bit 9, set), `irq` is 0 and `lp_commit` is 0.
- R2: A write to an address other than the status address (0x20) or the enable address (0x24), issued while busy (bit 10) is 0, sets busy and clears ready-for-next (bit 9) on the next bus clock.
- R3: An accepted write produces exactly one `lp_commit` pulse, one slow cycle wide. It is high after the 4th rising slow-clock edge that follows the bus edge accepting the write. `lp_addr` and `lp_data` then carry that write's address and data.
- R4: Once the slow side has committed, busy clears, done (bit 8) sets and ready-for-next returns in the bus domain.
- R5: A cycle with `rd_en` high clears done on the next bus clock. If the completion arrives in the same cycle as a read, done is set and not cleared.
- R6: A synchronized write issued while busy is 1 sets collision-error (bit 7), holds ready-for-next at 0 and is dropped. Only the first write is committed.
- R7: A write to the status address with data bit 7 = 1 clears collision-error. With data bit 7 = 0 it leaves the flag unchanged. Status writes never start a transfer.
- R8: A write to the enable address takes effect on the next bus clock. Its data bits 9, 8 and 7 enable ready-for-next, done and collision-error. It never sets busy or done and never reaches `lp_commit`.
- R9: `irq` is high exactly when some flag among ready-for-next, done and collision-error is set together with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| slow_clk | input | 1 | Slow retention-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain synchronously |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | AW (8) | Bus write address |
| wr_data | input | DW (32) | Bus write data |
| rd_en | input | 1 | Status read strobe, clears done |
| rd_status | output | 32 | Status word: bit 10 busy, 9 ready-for-next, 8 done, 7 collision-error |
| irq | output | 1 | Interrupt request, level |
| lp_commit | output | 1 | One slow-cycle commit strobe |
| lp_addr | output | AW (8) | Committed address, slow domain |
| lp_data | output | DW (32) | Committed data, slow domain |

## Verification
A status read and the return of the slow-side acknowledgement can land in the same bus cycle. One wants done cleared and the other wants it set. The bench provokes this by holding `rd_en` high every cycle from the write until busy drops. The sample in which busy first reads 0 must show done = 1, because the set must win. The following sample, with the read still active, must show done cleared.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

  localparam int STAT_W  = 32;
  localparam int ST_ERR  = 7;
  localparam int ST_DONE = 8;
  localparam int ST_NEXT = 9;
  localparam int ST_BUSY = 10;

  typedef struct packed {
    logic busy;
    logic done;
    logic err;
  } lpw_flags_t;

endpackage

// File: rtl/lpw_rst_sync.sv
module lpw_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign srst_n = sh_q[1];

endmodule

// File: rtl/lpw_sync_bit.sv
module lpw_sync_bit #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff_q[0] <= 1'b0;
          else        ff_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ff_q[i] <= 1'b0;
          else        ff_q[i] <= ff_q[i-1];
        end
      end
    end
  endgenerate

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/lpw_bus_ctrl.sv
module lpw_bus_ctrl
  import lpw_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          DW        = 32,
  parameter logic [AW-1:0] ADDR_STAT = 8'h20,
  parameter logic [AW-1:0] ADDR_IEN  = 8'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic              ack_sync,
  output logic              req_tgl,
  output logic [AW-1:0]     hold_addr,
  output logic [DW-1:0]     hold_data,
  output logic [STAT_W-1:0] status,
  output logic [2:0]        ien,
  output logic              irq
);

  lpw_flags_t    flg_q, flg_d;
  logic [2:0]    ien_q, ien_d;
  logic          req_q, req_d;
  logic          ack_prev_q;
  logic [AW-1:0] haddr_q;
  logic [DW-1:0] hdata_q;

  logic hit_stat, hit_ien, sync_wr, accept, reject, ack_evt, clr_err, nxt;

  always_comb begin
    hit_stat = (wr_addr == ADDR_STAT);
    hit_ien  = (wr_addr == ADDR_IEN);
    sync_wr  = wr_en && !hit_stat && !hit_ien;
    accept   = sync_wr && !flg_q.busy;
    reject   = sync_wr &&  flg_q.busy;
    clr_err  = wr_en && hit_stat && wr_data[ST_ERR];
    ack_evt  = ack_sync ^ ack_prev_q;
  end

  // next-state
  always_comb begin
    flg_d = flg_q;
    ien_d = ien_q;
    req_d = req_q;

    if (accept)       flg_d.busy = 1'b1;
    else if (ack_evt) flg_d.busy = 1'b0;

    // completion has priority over the clearing read
    if (ack_evt)    flg_d.done = 1'b1;
    else if (rd_en) flg_d.done = 1'b0;

    if (reject)       flg_d.err = 1'b1;
    else if (clr_err) flg_d.err = 1'b0;

    if (wr_en && hit_ien) ien_d = wr_data[ST_NEXT:ST_ERR];

    if (accept) req_d = ~req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q      <= '0;
      ien_q      <= '0;
      req_q      <= 1'b0;
      ack_prev_q <= 1'b0;
    end else begin
      flg_q      <= flg_d;
      ien_q      <= ien_d;
      req_q      <= req_d;
      ack_prev_q <= ack_sync;
    end
  end

  // hold registers, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haddr_q <= '0;
      hdata_q <= '0;
    end else if (accept) begin
      haddr_q <= wr_addr;
      hdata_q <= wr_data;
    end
  end

  always_comb begin
    nxt              = !flg_q.busy && !flg_q.err;
    status           = '0;
    status[ST_BUSY]  = flg_q.busy;
    status[ST_NEXT]  = nxt;
    status[ST_DONE]  = flg_q.done;
    status[ST_ERR]   = flg_q.err;
    irq              = |({nxt, flg_q.done, flg_q.err} & ien_q);
  end

  assign req_tgl   = req_q;
  assign hold_addr = haddr_q;
  assign hold_data = hdata_q;
  assign ien       = ien_q;

endmodule

// File: rtl/lpw_lp_commit.sv
module lpw_lp_commit #(
  parameter int AW            = 8,
  parameter int DW            = 32,
  parameter int SYNC_STAGES   = 2,
  parameter int COMMIT_CYCLES = 4   // must be at least SYNC_STAGES + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_tgl,
  input  logic [AW-1:0] hold_addr,
  input  logic [DW-1:0] hold_data,
  output logic          ack_tgl,
  output logic          lp_commit,
  output logic [AW-1:0] lp_addr,
  output logic [DW-1:0] lp_data
);

  localparam int EXTRA = COMMIT_CYCLES - SYNC_STAGES;
  localparam int CW    = $clog2(COMMIT_CYCLES + 1);

  logic          req_sync, req_prev_q, edge_seen;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          commit_q, commit_d;
  logic          ack_q, ack_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  lpw_sync_bit #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_tgl),
    .q     (req_sync)
  );

  always_comb begin
    edge_seen = req_sync ^ req_prev_q;
    cnt_d     = cnt_q;
    if (edge_seen)                 cnt_d = CW'(EXTRA - 1);
    else if (cnt_q != '0)          cnt_d = cnt_q - 1'b1;
    commit_d  = (cnt_q == CW'(1));
    ack_d     = ack_q ^ commit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev_q <= 1'b0;
      cnt_q      <= '0;
      commit_q   <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      req_prev_q <= req_sync;
      cnt_q      <= cnt_d;
      commit_q   <= commit_d;
      ack_q      <= ack_d;
    end
  end

  // bus-side hold registers are stable while the transfer is open
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (commit_d) begin
      addr_q <= hold_addr;
      data_q <= hold_data;
    end
  end

  assign ack_tgl   = ack_q;
  assign lp_commit = commit_q;
  assign lp_addr   = addr_q;
  assign lp_data   = data_q;

endmodule

// File: rtl/lp_write_bridge.sv
module lp_write_bridge
  import lpw_pkg::*;
#(
  parameter int            AW            = 8,
  parameter int            DW            = 32,
  parameter int            SYNC_STAGES   = 2,
  parameter int            COMMIT_CYCLES = 4,
  parameter logic [AW-1:0] ADDR_STAT     = 8'h20,
  parameter logic [AW-1:0] ADDR_IEN      = 8'h24
) (
  input  logic          bus_clk,
  input  logic          slow_clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [31:0]   rd_status,
  output logic          irq,
  output logic          lp_commit,
  output logic [AW-1:0] lp_addr,
  output logic [DW-1:0] lp_data
);

  logic          bus_rst_n, slow_rst_n;
  logic          req_tgl, ack_tgl, ack_sync;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;
  logic [2:0]    ien_bits;

  lpw_rst_sync u_bus_rst  (.clk(bus_clk),  .arst_n(rst_n), .srst_n(bus_rst_n));
  lpw_rst_sync u_slow_rst (.clk(slow_clk), .arst_n(rst_n), .srst_n(slow_rst_n));

  lpw_bus_ctrl #(
    .AW(AW), .DW(DW), .ADDR_STAT(ADDR_STAT), .ADDR_IEN(ADDR_IEN)
  ) u_bus (
    .clk       (bus_clk),
    .rst_n     (bus_rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .ack_sync  (ack_sync),
    .req_tgl   (req_tgl),
    .hold_addr (hold_addr),
    .hold_data (hold_data),
    .status    (rd_status),
    .ien       (ien_bits),
    .irq       (irq)
  );

  lpw_sync_bit #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (bus_clk),
    .rst_n (bus_rst_n),
    .d     (ack_tgl),
    .q     (ack_sync)
  );

  lpw_lp_commit #(
    .AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES), .COMMIT_CYCLES(COMMIT_CYCLES)
  ) u_lp (
    .clk       (slow_clk),
    .rst_n     (slow_rst_n),
    .req_tgl   (req_tgl),
    .hold_addr (hold_addr),
    .hold_data (hold_data),
    .ack_tgl   (ack_tgl),
    .lp_commit (lp_commit),
    .lp_addr   (lp_addr),
    .lp_data   (lp_data)
  );

endmodule

// File: rtl/lpw_bridge_chk.sv
module lpw_bridge_chk #(
  parameter int            AW        = 8,
  parameter logic [AW-1:0] ADDR_STAT = 8'h20,
  parameter logic [AW-1:0] ADDR_IEN  = 8'h24
) (
  input logic          bus_clk,
  input logic          slow_clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          rd_en,
  input logic [31:0]   rd_status,
  input logic          irq,
  input logic          lp_commit,
  input logic [2:0]    ien_bits
);

  logic sync_wr;
  assign sync_wr = wr_en && (wr_addr != ADDR_STAT) && (wr_addr != ADDR_IEN);

  // R2: accepted synchronized write raises busy
  a_r2_busy_on_accept: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (sync_wr && !rd_status[10]) |=> rd_status[10]);

  // R6: a write landing on a busy bridge flags the collision
  a_r6_err_on_collision: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (sync_wr && rd_status[10]) |=> (rd_status[7] && !rd_status[9]));

  // R5: done only drops after a status read
  a_r5_done_cleared_by_read: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $fell(rd_status[8]) |-> $past(rd_en));

  // R8: busy only rises after a synchronized write
  a_r8_busy_needs_sync_write: assert property (@(posedge bus_clk) disable iff (!rst_n)
    $rose(rd_status[10]) |-> $past(sync_wr));

  // R9: interrupt only with an enabled flag
  a_r9_irq_has_source: assert property (@(posedge bus_clk) disable iff (!rst_n)
    irq |-> |(ien_bits & rd_status[9:7]));

  // R3: commit strobe is a single slow cycle
  a_r3_commit_single: assert property (@(posedge slow_clk) disable iff (!rst_n)
    lp_commit |=> !lp_commit);

endmodule

bind lp_write_bridge lpw_bridge_chk #(
  .AW(AW), .ADDR_STAT(ADDR_STAT), .ADDR_IEN(ADDR_IEN)
) u_chk (
  .bus_clk   (bus_clk),
  .slow_clk  (slow_clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .rd_en     (rd_en),
  .rd_status (rd_status),
  .irq       (irq),
  .lp_commit (lp_commit),
  .ien_bits  (ien_bits)
);

// File: tb/lp_write_bridge_test.sv
module lp_write_bridge_test;

  localparam logic [7:0] A_STAT = 8'h20;
  localparam logic [7:0] A_IEN  = 8'h24;

  logic        bus_clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_status;
  logic        irq, lp_commit;
  logic [7:0]  lp_addr;
  logic [31:0] lp_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #2  bus_clk  = ~bus_clk;   // 250 MHz
  always #20 slow_clk = ~slow_clk;

  lp_write_bridge uut (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
    .rd_status(rd_status), .irq(irq), .lp_commit(lp_commit),
    .lp_addr(lp_addr), .lp_data(lp_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  // one write, driven at negedge, captured at the following posedge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read();
    @(negedge bus_clk);
    rd_en = 1'b1;
    @(negedge bus_clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      if (!rd_status[10]) break;
      @(negedge bus_clk);
    end
  endtask

  task automatic count_commits(input int edges, output int cnt, output logic [7:0] a, output logic [31:0] d);
    cnt = 0; a = '0; d = '0;
    for (int i = 0; i < edges; i++) begin
      @(posedge slow_clk); #1;
      if (lp_commit) begin cnt++; a = lp_addr; d = lp_data; end
    end
  endtask

  task automatic t_reset();
    @(negedge bus_clk);
    chk_eq("R1 status", rd_status, 32'h0000_0200);
    chk_eq("R1 irq", {31'd0, irq}, 32'd0);
    chk_eq("R1 lp_commit", {31'd0, lp_commit}, 32'd0);
  endtask

  task automatic t_basic();
    bit seen_early;
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = 8'h04; wr_data = 32'hCAFE_0123;
    @(posedge bus_clk); #1;
    wr_en = 1'b0;
    chk_eq("R2 busy set", rd_status[10:9], 2'b10);
    seen_early = 0;
    for (int i = 1; i <= 3; i++) begin
      @(posedge slow_clk); #1;
      if (lp_commit) seen_early = 1;
    end
    check(!seen_early, "R3 no early commit", {31'd0, seen_early}, 32'd0);
    @(posedge slow_clk); #1;
    chk_eq("R3 commit on 4th edge", {31'd0, lp_commit}, 32'd1);
    chk_eq("R3 lp_addr", {24'd0, lp_addr}, 32'h04);
    chk_eq("R3 lp_data", lp_data, 32'hCAFE_0123);
    @(posedge slow_clk); #1;
    chk_eq("R3 single pulse", {31'd0, lp_commit}, 32'd0);
    @(negedge bus_clk);
    wait_idle();
    chk_eq("R4 done, next, not busy", rd_status, 32'h0000_0300);
    bus_read();
    chk_eq("R5 read clears done", rd_status, 32'h0000_0200);
  endtask

  task automatic t_collision();
    int cnt; logic [7:0] a; logic [31:0] d;
    bus_write(8'h08, 32'h1111_AAAA);
    bus_write(8'h0C, 32'h2222_BBBB);
    chk_eq("R6 error and busy", rd_status[10:7], 4'b1001);
    count_commits(12, cnt, a, d);
    chk_eq("R6 one commit", cnt, 1);
    chk_eq("R6 first write kept", {a, d[23:0]}, {8'h08, 24'h11AAAA});
    wait_idle();
    bus_read();
    chk_eq("R6 error persists idle", rd_status, 32'h0000_0080);
    bus_write(A_STAT, 32'h0000_0000);
    chk_eq("R7 bit7=0 keeps error", rd_status, 32'h0000_0080);
    bus_write(A_STAT, 32'h0000_0080);
    chk_eq("R7 bit7=1 clears error", rd_status, 32'h0000_0200);
    count_commits(8, cnt, a, d);
    chk_eq("R7 status writes never commit", cnt, 0);
  endtask

  task automatic t_read_vs_done();
    bit got_idle;
    bus_write(8'h10, 32'h0000_5A5A);
    @(negedge bus_clk);
    rd_en = 1'b1;
    got_idle = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge bus_clk);
      if (!rd_status[10]) begin got_idle = 1; break; end
    end
    chk_eq("R5 set wins over read", {31'd0, rd_status[8]}, 32'd1);
    @(negedge bus_clk);
    chk_eq("R5 next read clears", {31'd0, rd_status[8]}, 32'd0);
    rd_en = 1'b0;
    check(got_idle, "R4 busy released", {31'd0, got_idle}, 32'd1);
  endtask

  task automatic t_ien_irq();
    int cnt; logic [7:0] a; logic [31:0] d;
    bus_write(A_IEN, 32'h0000_0200);
    chk_eq("R8 enable immediate (next irq)", {31'd0, irq}, 32'd1);
    chk_eq("R8 no busy/done", rd_status, 32'h0000_0200);
    count_commits(8, cnt, a, d);
    chk_eq("R8 no commit", cnt, 0);
    bus_write(A_IEN, 32'h0000_0100);
    chk_eq("R9 done disabled source idle", {31'd0, irq}, 32'd0);
    bus_write(8'h30, 32'h0000_0001);
    wait_idle();
    @(negedge bus_clk);
    chk_eq("R9 irq on done", {31'd0, irq}, 32'd1);
    bus_read();
    chk_eq("R9 irq drops after read", {31'd0, irq}, 32'd0);
    bus_write(A_IEN, 32'h0000_0080);
    bus_write(8'h34, 32'h0000_0002);
    chk_eq("R9 no irq before error", {31'd0, irq}, 32'd0);
    bus_write(8'h38, 32'h0000_0003);
    chk_eq("R9 irq on error", {31'd0, irq}, 32'd1);
    wait_idle();
    bus_write(A_STAT, 32'h0000_0080);
    chk_eq("R9 irq gone after clear", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    #40_000;
    if (!done_flag) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #53;
    rst_n = 1'b1;
    repeat (3) @(posedge slow_clk);
    t_reset();
    t_basic();
    t_collision();
    t_read_vs_done();
    t_ien_irq();
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule